// File: doc/BRIEF.md
# Vector String Isolate Unit

This unit takes one 128-bit vector operand and a 32-bit instruction word. It walks the operand's elements in a chosen direction, one way or the other, and keeps every element up to, but not including, the first element that is zero. The zero element and everything that follows it in walk order are cleared. Elements are bytes (16 lanes) or halfwords (8 lanes). A 4-bit condition value reports whether a zero element was seen. The instruction's record bit decides whether that condition value is committed.

The instruction word is decoded inside the unit. It supplies the element size, the walk direction, the target and source register numbers and the record bit. An unrecognised encoding is flagged and produces no writes. Operands enter on a valid/ready handshake. Results leave one cycle later from a single output register stage, and that stage holds its contents while the consumer stalls.

Top module: `vsi_string_isolate`

## Requirements
- R1: An instruction is legal when bits [31:26] are 000100, bits [9:0] are 0000001101 and the variant field bits [20:16] is 0 to 3. The target register number, bits [25:21], is returned on `tgtReg` with the result. The source register number, bits [15:11], appears combinationally on `srcReg`.
- R2: Variant 0 (byte, forward) walks byte lanes from index 0 to 15, where byte i is operand bits [127-8i -: 8]. Lanes before the first zero byte are copied unchanged. That byte and all higher lanes read zero.
- R3: Variant 1 (byte, backward) walks from byte 15 down to byte 0. Lanes above the first zero byte found are copied. That byte and all lower lanes read zero.
- R4: Variants 2 and 3 (halfword, forward or backward) do the same over 8 halfword lanes, where halfword i is bits [127-16i -: 16]. A halfword counts as zero only when both of its bytes are zero.
- R5: When no element is zero, the result equals the operand and the condition value is 0000.
- R6: When a zero element is found, the condition value is 0010.
- R7: For a legal instruction, `vecWe` is 1 and `crWe` equals the record bit, bit 10.
- R8: For an illegal instruction, `illegalInsn` is 1 and both `vecWe` and `crWe` are 0.
- R9: `inReady` equals !outValid || outReady. An accepted operation appears with `outValid` on the next cycle. While `outValid` is high and `outReady` is low, the outputs hold. When the stage drains with no new input, `outValid` falls.
- R10: While reset is asserted, `outValid`, `vecWe`, `crWe` and `illegalInsn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation accepted this cycle when inValid is high |
| insnWord | input | 32 | Instruction word |
| srcVec | input | 128 | Vector operand |
| srcReg | output | 5 | Source register number decoded from insnWord |
| outValid | output | 1 | Result stage holds an operation |
| outReady | input | 1 | Consumer takes the result |
| resVec | output | 128 | Isolated vector result |
| crField | output | 4 | Condition value, 0010 on a zero element, else 0000 |
| crWe | output | 1 | Commit crField to the condition field |
| vecWe | output | 1 | Commit resVec to the target register |
| tgtReg | output | 5 | Target register number |
| illegalInsn | output | 1 | Instruction encoding not recognised |

## Verification
A wrong prefix scan, or a wrong lane-to-bit mapping, shows up as a result in which the clear boundary sits in the wrong lane. It is seen on the very next output cycle after the operation, so the sweep places a single zero element at every position for all four variants. A wrong halfword zero test only appears when a halfword has exactly one zero byte, so that pattern is driven on purpose. Decode or stall faults show at once as a bad write enable, a lost register number, or a result that changes while the consumer stalls.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int CR_W   = 4;
  localparam logic [5:0] PRIM_OP = 6'b000100;
  localparam logic [9:0] EXT_OP  = 10'b0000001101;
  localparam logic [CR_W-1:0] CR_HIT  = 4'b0010;
  localparam logic [CR_W-1:0] CR_MISS = 4'b0000;

  typedef struct packed {
    logic load;
    logic halfMode;
    logic scanRight;
  } dpStrobe_t;
endpackage

// File: rtl/vsi_ctrl.sv
module vsi_ctrl
  import vsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [INSN_W-1:0] insnWord,
  input  logic              outReady,
  output dpStrobe_t         strobe,
  output logic [REG_W-1:0]  srcReg,
  output logic              outValid,
  output logic              vecWe,
  output logic              crWe,
  output logic [REG_W-1:0]  tgtReg,
  output logic              illegalInsn
);
  logic [5:0]       opField;
  logic [REG_W-1:0] tgtField;
  logic [4:0]       variantField;
  logic             recordBit;
  logic [9:0]       xoField;
  logic             legal;
  logic             fire;

  assign opField      = insnWord[31:26];
  assign tgtField     = insnWord[25:21];
  assign variantField = insnWord[20:16];
  assign srcReg       = insnWord[15:11];
  assign recordBit    = insnWord[10];
  assign xoField      = insnWord[9:0];

  assign legal   = (opField == PRIM_OP) && (xoField == EXT_OP) && (variantField[4:2] == 3'b000);
  assign inReady = !outValid || outReady;
  assign fire    = inValid && inReady;

  assign strobe.load      = fire;
  assign strobe.halfMode  = variantField[1];
  assign strobe.scanRight = variantField[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      vecWe       <= 1'b0;
      crWe        <= 1'b0;
      illegalInsn <= 1'b0;
      tgtReg      <= '0;
    end else if (fire) begin
      outValid    <= 1'b1;
      vecWe       <= legal;
      crWe        <= legal && recordBit;
      illegalInsn <= !legal;
      tgtReg      <= tgtField;
    end else if (outReady) begin
      outValid    <= 1'b0;
      vecWe       <= 1'b0;
      crWe        <= 1'b0;
      illegalInsn <= 1'b0;
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    illegalInsn |-> (!vecWe && !crWe && outValid)); // R8

  AST_CRWE_NEEDS_VECWE: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> vecWe); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(tgtReg) && $stable(vecWe) && $stable(crWe))); // R9

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid); // R9
endmodule

// File: rtl/vsi_scan.sv
module vsi_scan
  import vsi_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VEC_W-1:0] srcVec,
  output logic [VEC_W-1:0] resVec,
  output logic [CR_W-1:0]  crField
);
  localparam int BYTE_N = VEC_W / 8;

  logic [BYTE_N-1:0] byteZero;
  logic [BYTE_N-1:0] laneZero;
  logic [BYTE_N-1:0] keepMask;
  logic [VEC_W-1:0]  maskedVec;
  logic              found;
  logic              seen;

  for (genvar g = 0; g < BYTE_N; g++) begin : g_lane
    assign byteZero[g] = ~|srcVec[VEC_W-1-8*g -: 8];
    assign laneZero[g] = strobe.halfMode ? (byteZero[g] && byteZero[g ^ 1]) : byteZero[g];
    assign maskedVec[VEC_W-1-8*g -: 8] = keepMask[g] ? srcVec[VEC_W-1-8*g -: 8] : 8'h00;
  end

  always_comb begin
    keepMask = '0;
    seen     = 1'b0;
    for (int k = 0; k < BYTE_N; k++) begin
      int idx;
      idx = strobe.scanRight ? (BYTE_N - 1 - k) : k;
      seen = seen || laneZero[idx];
      keepMask[idx] = !seen;
    end
  end

  assign found = |laneZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resVec  <= '0;
      crField <= CR_MISS;
    end else if (strobe.load) begin
      resVec  <= maskedVec;
      crField <= found ? CR_HIT : CR_MISS;
    end
  end

  AST_CR_ENCODING: assert property (@(posedge clk) disable iff (!rstN)
    (crField == CR_HIT) || (crField == CR_MISS)); // R6

  AST_NONZERO_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !found) |=> (resVec == $past(srcVec) && crField == CR_MISS)); // R5

  AST_FIRST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && laneZero[strobe.scanRight ? BYTE_N-1 : 0]) |=> (resVec == '0 && crField == CR_HIT)); // R2
endmodule

// File: rtl/vsi_string_isolate.sv
module vsi_string_isolate
  import vsi_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [31:0]      insnWord,
  input  logic [VEC_W-1:0] srcVec,
  output logic [4:0]       srcReg,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] resVec,
  output logic [3:0]       crField,
  output logic             crWe,
  output logic             vecWe,
  output logic [4:0]       tgtReg,
  output logic             illegalInsn
);
  dpStrobe_t strobe;

  vsi_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inReady     (inReady),
    .insnWord    (insnWord),
    .outReady    (outReady),
    .strobe      (strobe),
    .srcReg      (srcReg),
    .outValid    (outValid),
    .vecWe       (vecWe),
    .crWe        (crWe),
    .tgtReg      (tgtReg),
    .illegalInsn (illegalInsn)
  );

  vsi_scan #(.VEC_W(VEC_W)) scan_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcVec  (srcVec),
    .resVec  (resVec),
    .crField (crField)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!outValid && !vecWe && !crWe && !illegalInsn)); // R10
endmodule

// File: tb/vsi_string_isolate_tb_top.sv
module vsi_string_isolate_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [31:0]  insnWord;
  logic [127:0] srcVec;
  logic [4:0]   srcReg;
  logic         outValid;
  logic         outReady;
  logic [127:0] resVec;
  logic [3:0]   crField;
  logic         crWe;
  logic         vecWe;
  logic [4:0]   tgtReg;
  logic         illegalInsn;

  int nChk  = 0;
  int nFail = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  vsi_string_isolate dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .insnWord(insnWord), .srcVec(srcVec), .srcReg(srcReg),
    .outValid(outValid), .outReady(outReady), .resVec(resVec),
    .crField(crField), .crWe(crWe), .vecWe(vecWe), .tgtReg(tgtReg),
    .illegalInsn(illegalInsn)
  );

  function automatic logic [31:0] mkInsn(input logic [5:0] op, input logic [4:0] tgt,
                                         input logic [4:0] vsel, input logic [4:0] src,
                                         input logic rc, input logic [9:0] xo);
    return {op, tgt, vsel, src, rc, xo};
  endfunction

  function automatic logic [127:0] refIsolate(input logic [127:0] v, input int variant,
                                              output logic hit);
    int esz;
    int n;
    logic [127:0] r;
    esz = (variant >= 2) ? 16 : 8;
    n   = 128 / esz;
    r   = '0;
    hit = 1'b0;
    for (int k = 0; k < n; k++) begin
      int e;
      int sh;
      logic [15:0] el;
      e  = (variant % 2 == 1) ? (n - 1 - k) : k;
      sh = 128 - esz * (e + 1);
      el = 16'(v >> sh) & ((esz == 8) ? 16'h00ff : 16'hffff);
      if (el == 16'h0) hit = 1'b1;
      if (!hit) r = r | ({112'b0, el} << sh);
    end
    return r;
  endfunction

  function automatic logic [127:0] nzVec(input int seed);
    logic [127:0] v;
    for (int b = 0; b < 16; b++) v[127-8*b -: 8] = 8'(b * 13 + 1 + seed);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] insn, input logic [127:0] vec);
    @(negedge clk);
    inValid  = 1'b1;
    insnWord = insn;
    srcVec   = vec;
    @(negedge clk);
    inValid  = 1'b0;
  endtask

  task automatic doLegal(input int variant, input logic rc, input logic [127:0] vec, input string req);
    logic hit;
    logic [127:0] exp;
    logic [4:0] tgt;
    exp = refIsolate(vec, variant, hit);
    tgt = 5'(variant * 7 + 3);
    issue(mkInsn(6'b000100, tgt, 5'(variant), 5'd9, rc, 10'b0000001101), vec);
    chk(outValid && resVec == exp, req, resVec, exp);
    chk(crField == (hit ? 4'b0010 : 4'b0000), hit ? "R6 cond on zero" : "R5 cond no zero",
        128'(crField), hit ? 128'h2 : 128'h0);
    chk(vecWe && (crWe == rc) && !illegalInsn, "R7 write enables",
        128'({vecWe, crWe, illegalInsn}), 128'({1'b1, rc, 1'b0}));
    chk(tgtReg == tgt, "R1 target number", 128'(tgtReg), 128'(tgt));
  endtask

  task automatic doIllegal(input logic [31:0] insn);
    issue(insn, nzVec(0));
    chk(outValid && illegalInsn && !vecWe && !crWe, "R8 illegal suppresses writes",
        128'({outValid, illegalInsn, vecWe, crWe}), 128'(4'b1100));
  endtask

  function automatic string tagOf(input int variant);
    case (variant)
      0: return "R2 byte forward";
      1: return "R3 byte backward";
      default: return "R4 halfword";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1; insnWord = '0; srcVec = '0;
    repeat (3) @(negedge clk);
    chk(!outValid && !vecWe && !crWe && !illegalInsn, "R10 reset state",
        128'({outValid, vecWe, crWe, illegalInsn}), 128'h0);
    rstN = 1'b1;

    // R1: source register number is combinational
    @(negedge clk);
    insnWord = mkInsn(6'b000100, 5'd1, 5'd0, 5'd22, 1'b1, 10'b0000001101);
    #1;
    chk(srcReg == 5'd22, "R1 source number", 128'(srcReg), 128'd22);

    // All-nonzero, and a single zero element at every position
    for (int variant = 0; variant < 4; variant++) begin
      int n;
      n = (variant >= 2) ? 8 : 16;
      doLegal(variant, 1'b1, nzVec(variant), "R5 all nonzero");
      for (int p = 0; p < n; p++) begin
        logic [127:0] v;
        v = nzVec(variant + p);
        if (n == 16) v[127-8*p -: 8] = 8'h00;
        else v[127-16*p -: 16] = 16'h0000;
        doLegal(variant, 1'b1, v, tagOf(variant));
      end
      doLegal(variant, 1'b0, '0, "R7 record clear, all zero");
    end

    // R4: halfwords each holding a single zero byte are not zero
    begin
      logic [127:0] v;
      v = nzVec(3);
      for (int h = 0; h < 8; h++) v[127-16*h-((h % 2) * 8) -: 8] = 8'h00;
      doLegal(2, 1'b1, v, "R4 half-zero halfword forward");
      doLegal(3, 1'b1, v, "R4 half-zero halfword backward");
      doLegal(0, 1'b1, v, "R2 byte sees zero byte");
    end

    // Mixed pseudo-random operands
    for (int t = 0; t < 200; t++) begin
      logic [127:0] v;
      for (int w = 0; w < 4; w++) begin
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        v[32*w +: 32] = lfsr;
      end
      for (int b = 0; b < 16; b++) begin
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        if (lfsr[3:0] < 4'd3) v[8*b +: 8] = 8'h00;
      end
      doLegal(t % 4, 1'(t % 3 != 0), v, tagOf(t % 4));
    end

    // R8: bad variant, bad primary opcode, bad extended opcode
    for (int vs = 4; vs < 32; vs += 3)
      doIllegal(mkInsn(6'b000100, 5'd5, 5'(vs), 5'd1, 1'b1, 10'b0000001101));
    doIllegal(mkInsn(6'b000101, 5'd5, 5'd0, 5'd1, 1'b1, 10'b0000001101));
    doIllegal(mkInsn(6'b000100, 5'd5, 5'd1, 5'd1, 1'b1, 10'b0000001100));
    doIllegal(mkInsn(6'b000100, 5'd5, 5'd2, 5'd1, 1'b0, 10'b1000001101));

    // R9: backpressure and drain
    begin
      logic hitA, hitB;
      logic [127:0] va, vb, ea, eb;
      va = nzVec(1); va[127-8*5 -: 8] = 8'h00;
      vb = nzVec(2); vb[127-16*6 -: 16] = 16'h0000;
      ea = refIsolate(va, 0, hitA);
      eb = refIsolate(vb, 3, hitB);
      @(negedge clk);
      outReady = 1'b0;
      inValid = 1'b1;
      insnWord = mkInsn(6'b000100, 5'd11, 5'd0, 5'd2, 1'b1, 10'b0000001101);
      srcVec = va;
      @(negedge clk);
      chk(outValid && !inReady && resVec == ea, "R9 accept then stall", resVec, ea);
      insnWord = mkInsn(6'b000100, 5'd12, 5'd3, 5'd2, 1'b0, 10'b0000001101);
      srcVec = vb;
      @(negedge clk);
      chk(outValid && resVec == ea && tgtReg == 5'd11 && crWe, "R9 hold while stalled", resVec, ea);
      outReady = 1'b1;
      #1;
      chk(inReady == 1'b1, "R9 ready with consumer", 128'(inReady), 128'h1);
      @(negedge clk);
      chk(outValid && resVec == eb && tgtReg == 5'd12 && !crWe, "R9 next op after stall", resVec, eb);
      inValid = 1'b0;
      @(negedge clk);
      chk(!outValid && !vecWe, "R9 drained", 128'({outValid, vecWe}), 128'h0);
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule